// File: doc/BRIEF.md
# DRAM Performance Monitor Counter Bank

This block counts activity reported by a memory controller. It has a bank of programmable event counters and a pair of fixed counters. One fixed counter counts DRAM writes and the other counts DRAM reads. Each programmable counter watches a vector of single-cycle event inputs. Its own configuration word holds an enable bit and a one-hot event mask. Software drives the block through a flat 64-bit register port. The port has an address, a write strobe and write data. Read data is combinational from the address.

Each programmable counter holds a small run-control state machine with two states, `ST_IDLE` and `ST_RUN`. A write of 1 to bit 0 of the counter's start register takes `ST_IDLE` to `ST_RUN`. A write of 1 to bit 0 of its end register takes `ST_RUN` to `ST_IDLE`. Any other stimulus keeps the current state. Counters are started and stopped one at a time. A counter adds one in a cycle only when all of these hold:

- its enable bit is set;
- its mode register selects manual mode;
- it is in `ST_RUN`;
- at least one event input selected by its mask is high.

The fixed counters have one control register holding their enables and a separate clear register.

Top module: `dram_perfmon`

## Requirements
- R1: After reset, every readable register and every counter reads zero.
- R2: Configuration register n is at 0x20160+8n. Bit 63 is the counter enable and bits 60:0 are the event mask, with event identifier N (1 to 61) on bit N-1. Bits 62:61 read back as zero.
- R3: A programmable counter adds one at a clock edge only if, in the cycle before that edge, all of these held:
  - its enable bit was set;
  - its mode register (0x20020+8n) held 1 in bit 0;
  - it was in `ST_RUN`;
  - a selected event input was high.
- R4: When several mask bits are set, the counter adds exactly one in each cycle in which any selected input is high.
- R5: Writing bit 0 = 1 at start register 0x200A0+8n enters `ST_RUN`. Writing bit 0 = 1 at end register 0x200E0+8n returns the counter to `ST_IDLE`. Bit 1 of the start register reads 1 exactly in `ST_RUN`. Every counter is controlled independently.
- R6: The fixed control register at 0x20240 holds the write-counter enable in bit 0 and the read-counter enable in bit 1. An enabled fixed counter adds one per cycle in which its pulse input is high.
- R7: Writing to 0x20248 clears the write counter when bit 0 is 1 and the read counter when bit 1 is 1. A clear in the same cycle as an increment leaves the counter at zero.
- R8: Counters wrap from all ones to zero and report no overflow indication.
- R9: Reads return zero at unmapped or misaligned offsets and at the end-status offset 0x20120. Writes to unmapped offsets and to counter value offsets change nothing.
- R10: Programmable counter n reads at 0x201C0+8n. The write counter reads at 0x20250 and the read counter at 0x20258.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 18 | Register byte offset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| evt_in | input | 61 | Event inputs; bit N-1 is event identifier N |
| dram_wr_pulse | input | 1 | One DRAM write in this cycle |
| dram_rd_pulse | input | 1 | One DRAM read in this cycle |

## Verification
The sharpest collision is a fixed-counter clear written in the same cycle as a live write pulse. The bench holds the pulse high across the register write of the clear and expects zero immediately afterwards, not one. It then expects counting to resume on the following edge. A second overlap is an end-register write while the selected event stays high. The bench checks that the edge carrying the stop still counts and that later edges do not.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
    localparam int unsigned ADDR_W = 18;

    localparam logic [ADDR_W-1:0] OFS_MODE    = 18'h20020;
    localparam logic [ADDR_W-1:0] OFS_START   = 18'h200A0;
    localparam logic [ADDR_W-1:0] OFS_STOP    = 18'h200E0;
    localparam logic [ADDR_W-1:0] OFS_CFG     = 18'h20160;
    localparam logic [ADDR_W-1:0] OFS_VAL     = 18'h201C0;
    localparam logic [ADDR_W-1:0] OFS_FIX_CTL = 18'h20240;
    localparam logic [ADDR_W-1:0] OFS_FIX_CLR = 18'h20248;
    localparam logic [ADDR_W-1:0] OFS_FIX_WR  = 18'h20250;
    localparam logic [ADDR_W-1:0] OFS_FIX_RD  = 18'h20258;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/pm_prog_ctr.sv
module pm_prog_ctr
    import perfmon_pkg::*;
#(
    parameter int unsigned EVT_W = 61,
    parameter int unsigned CTR_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic             mode_bit,
    input  logic             cfg_we,
    input  logic [63:0]      cfg_wdata,
    input  logic             start_stb,
    input  logic             stop_stb,
    input  logic [EVT_W-1:0] evt,
    output logic             mode_q,
    output logic [63:0]      cfg_q,
    output logic             active,
    output logic [CTR_W-1:0] cnt_q
);
    localparam logic [63:0] CFG_MASK = {1'b1, {(63-EVT_W){1'b0}}, {EVT_W{1'b1}}};

    run_state_t state_q, state_d;
    logic       hit, inc;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_stb) state_d = ST_RUN;
            ST_RUN:  if (stop_stb)  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        active = (state_q == ST_RUN);
        hit    = |(evt & cfg_q[EVT_W-1:0]);
        inc    = cfg_q[63] && mode_q && active && hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            cfg_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (mode_we) mode_q <= mode_bit;
            if (cfg_we)  cfg_q  <= cfg_wdata & CFG_MASK;
            if (inc)     cnt_q  <= cnt_q + 1'b1;
        end
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> cnt_q == $past(cnt_q) + 1'b1); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(cnt_q)); // R3
    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |=> (state_q == ST_IDLE)); // R5
endmodule

// File: rtl/pm_fixed_ctr.sv
module pm_fixed_ctr #(
    parameter int unsigned CTR_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_bit,
    input  logic             clr_stb,
    input  logic             pulse,
    output logic             en_q,
    output logic [CTR_W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (ctl_we) en_q <= ctl_bit;
            if (clr_stb)            cnt_q <= '0;
            else if (en_q && pulse) cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (cnt_q == '0)); // R7
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !clr_stb) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/dram_perfmon.sv
module dram_perfmon
    import perfmon_pkg::*;
#(
    parameter int unsigned NUM_PROG = 8,
    parameter int unsigned EVT_W    = 61,
    parameter int unsigned CTR_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic [EVT_W-1:0]  evt_in,
    input  logic              dram_wr_pulse,
    input  logic              dram_rd_pulse
);
    localparam int unsigned STRIDE = 8;

    logic [NUM_PROG-1:0] mode_q, active;
    logic [63:0]         cfg_q [NUM_PROG];
    logic [CTR_W-1:0]    cnt_q [NUM_PROG];
    logic                fwr_en, frd_en;
    logic [CTR_W-1:0]    fwr_cnt, frd_cnt;
    logic                rd_hit;

    for (genvar i = 0; i < NUM_PROG; i++) begin : g_prog
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(STRIDE * i);
        logic sel_mode, sel_cfg, sel_start, sel_stop;
        always_comb begin
            sel_mode  = reg_wr_en && (reg_addr == OFS_MODE  + OFF);
            sel_cfg   = reg_wr_en && (reg_addr == OFS_CFG   + OFF);
            sel_start = reg_wr_en && (reg_addr == OFS_START + OFF) && reg_wdata[0];
            sel_stop  = reg_wr_en && (reg_addr == OFS_STOP  + OFF) && reg_wdata[0];
        end
        pm_prog_ctr #(.EVT_W(EVT_W), .CTR_W(CTR_W)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_we   (sel_mode),
            .mode_bit  (reg_wdata[0]),
            .cfg_we    (sel_cfg),
            .cfg_wdata (reg_wdata),
            .start_stb (sel_start),
            .stop_stb  (sel_stop),
            .evt       (evt_in),
            .mode_q    (mode_q[i]),
            .cfg_q     (cfg_q[i]),
            .active    (active[i]),
            .cnt_q     (cnt_q[i])
        );
    end

    logic fix_ctl_we, fix_clr_we;
    always_comb begin
        fix_ctl_we = reg_wr_en && (reg_addr == OFS_FIX_CTL);
        fix_clr_we = reg_wr_en && (reg_addr == OFS_FIX_CLR);
    end

    pm_fixed_ctr #(.CTR_W(CTR_W)) u_fix_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (fix_ctl_we),
        .ctl_bit (reg_wdata[0]),
        .clr_stb (fix_clr_we && reg_wdata[0]),
        .pulse   (dram_wr_pulse),
        .en_q    (fwr_en),
        .cnt_q   (fwr_cnt)
    );

    pm_fixed_ctr #(.CTR_W(CTR_W)) u_fix_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (fix_ctl_we),
        .ctl_bit (reg_wdata[1]),
        .clr_stb (fix_clr_we && reg_wdata[1]),
        .pulse   (dram_rd_pulse),
        .en_q    (frd_en),
        .cnt_q   (frd_cnt)
    );

    always_comb begin
        reg_rdata = '0;
        rd_hit    = 1'b0;
        for (int i = 0; i < NUM_PROG; i++) begin
            if (reg_addr == OFS_MODE + ADDR_W'(STRIDE * i)) begin
                reg_rdata = {63'd0, mode_q[i]};
                rd_hit    = 1'b1;
            end
            if (reg_addr == OFS_START + ADDR_W'(STRIDE * i)) begin
                reg_rdata = {62'd0, active[i], 1'b0};
                rd_hit    = 1'b1;
            end
            if (reg_addr == OFS_CFG + ADDR_W'(STRIDE * i)) begin
                reg_rdata = cfg_q[i];
                rd_hit    = 1'b1;
            end
            if (reg_addr == OFS_VAL + ADDR_W'(STRIDE * i)) begin
                reg_rdata = 64'(cnt_q[i]);
                rd_hit    = 1'b1;
            end
        end
        if (reg_addr == OFS_FIX_CTL) begin
            reg_rdata = {62'd0, frd_en, fwr_en};
            rd_hit    = 1'b1;
        end
        if (reg_addr == OFS_FIX_WR) begin
            reg_rdata = 64'(fwr_cnt);
            rd_hit    = 1'b1;
        end
        if (reg_addr == OFS_FIX_RD) begin
            reg_rdata = 64'(frd_cnt);
            rd_hit    = 1'b1;
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (reg_rdata == 64'd0)); // R9
    AST_ACTIVE_ONEHOT0_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active & ~$past(active)) || $countones(active & ~$past(active)) == 0); // R5
endmodule

// File: tb/sim_dram_perfmon.sv
module sim_dram_perfmon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata, rdata_small;
    logic [60:0] evt_in = '0;
    logic        dram_wr_pulse = 1'b0;
    logic        dram_rd_pulse = 1'b0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dram_perfmon u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .dram_wr_pulse(dram_wr_pulse), .dram_rd_pulse(dram_rd_pulse)
    );

    dram_perfmon #(.CTR_W(4)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_small), .evt_in(evt_in),
        .dram_wr_pulse(dram_wr_pulse), .dram_rd_pulse(dram_rd_pulse)
    );

    localparam logic [17:0] A_MODE = 18'h20020, A_START = 18'h200A0, A_STOP = 18'h200E0;
    localparam logic [17:0] A_CFG = 18'h20160, A_VAL = 18'h201C0, A_DONE = 18'h20120;
    localparam logic [17:0] A_FCTL = 18'h20240, A_FCLR = 18'h20248;
    localparam logic [17:0] A_FWR = 18'h20250, A_FRD = 18'h20258;
    localparam logic [63:0] EN = 64'h8000_0000_0000_0000;

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [17:0] a, logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [17:0] a, output logic [63:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_chk(string req, logic [17:0] a, logic [63:0] exp);
        logic [63:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pulse_evt(logic [60:0] m, int n);
        @(negedge clk);
        evt_in = m;
        repeat (n) @(negedge clk);
        evt_in = '0;
    endtask

    task automatic t_reset;
        rd_chk("R1 cfg0", A_CFG, 0);
        rd_chk("R1 val0", A_VAL, 0);
        rd_chk("R1 start0", A_START, 0);
        rd_chk("R1 mode7", A_MODE + 56, 0);
        rd_chk("R1 fixctl", A_FCTL, 0);
        rd_chk("R1 fixwr", A_FWR, 0);
        rd_chk("R1 fixrd", A_FRD, 0);
    endtask

    task automatic t_cfg;
        wr(A_CFG + 8, '1);
        rd_chk("R2 cfg1 mask", A_CFG + 8, 64'h9FFF_FFFF_FFFF_FFFF);
        wr(A_CFG + 8, 0);
        rd_chk("R2 cfg1 clear", A_CFG + 8, 0);
    endtask

    task automatic t_gating;
        // event id 5 -> bit 4
        wr(A_CFG, EN | 64'h10);
        wr(A_START, 1);
        rd_chk("R5 active bit1", A_START, 2);
        pulse_evt(61'h10, 3);
        rd_chk("R3 no mode", A_VAL, 0);
        wr(A_MODE, 1);
        rd_chk("R3 mode reads", A_MODE, 1);
        pulse_evt(61'h10, 4);
        pulse_evt(61'h20, 2);
        rd_chk("R3 counts selected only", A_VAL, 4);
        wr(A_CFG, 64'h10);
        pulse_evt(61'h10, 2);
        rd_chk("R3 enable gate", A_VAL, 4);
        wr(A_CFG, EN | 64'h10);
        // stop while event held: stop edge still counts
        @(negedge clk);
        evt_in = 61'h10;
        wr(A_STOP, 1);
        @(negedge clk);
        evt_in = '0;
        rd_chk("R5 stop edge", A_VAL, 6);
        rd_chk("R5 inactive", A_START, 0);
        pulse_evt(61'h10, 3);
        rd_chk("R5 stopped holds", A_VAL, 6);
    endtask

    task automatic t_independent;
        wr(A_CFG + 24, EN | (64'h1 << 60));
        wr(A_MODE + 24, 1);
        wr(A_START + 24, 1);
        pulse_evt(61'h1 << 60, 5);
        rd_chk("R5 ctr3 counts id61", A_VAL + 24, 5);
        rd_chk("R5 ctr0 unaffected", A_VAL, 6);
        rd_chk("R5 ctr0 still idle", A_START, 0);
    endtask

    task automatic t_multi;
        wr(A_CFG + 16, EN | 64'h3);
        wr(A_MODE + 16, 1);
        wr(A_START + 16, 1);
        pulse_evt(61'h1, 1);
        pulse_evt(61'h3, 2);
        pulse_evt(61'h2, 1);
        rd_chk("R4 any selected", A_VAL + 16, 4);
    endtask

    task automatic t_wrap;
        wr(A_CFG + 40, EN | 64'h80);
        wr(A_MODE + 40, 1);
        wr(A_START + 40, 1);
        pulse_evt(61'h80, 17);
        rd_chk("R10 ctr5 value", A_VAL + 40, 17);
        begin
            logic [63:0] d;
            reg_addr = A_VAL + 40;
            #1 d = rdata_small;
            chk("R8 4-bit wrap", d, 1);
        end
    endtask

    task automatic t_fixed;
        @(negedge clk);
        dram_wr_pulse = 1; dram_rd_pulse = 1;
        repeat (2) @(negedge clk);
        dram_wr_pulse = 0; dram_rd_pulse = 0;
        rd_chk("R6 disabled wr", A_FWR, 0);
        wr(A_FCTL, 1);
        rd_chk("R6 ctl readback", A_FCTL, 1);
        @(negedge clk);
        dram_wr_pulse = 1; dram_rd_pulse = 1;
        repeat (3) @(negedge clk);
        dram_wr_pulse = 0; dram_rd_pulse = 0;
        rd_chk("R6 wr count", A_FWR, 3);
        rd_chk("R6 rd disabled", A_FRD, 0);
        wr(A_FCTL, 3);
        @(negedge clk);
        dram_rd_pulse = 1;
        repeat (2) @(negedge clk);
        dram_rd_pulse = 0;
        rd_chk("R6 rd count", A_FRD, 2);
    endtask

    task automatic t_clear;
        @(negedge clk);
        dram_wr_pulse = 1;
        reg_addr = A_FCLR; reg_wdata = 1; reg_wr_en = 1;
        @(negedge clk);
        reg_wr_en = 0; reg_wdata = 0;
        dram_wr_pulse = 0;
        rd_chk("R7 clear beats inc", A_FWR, 0);
        rd_chk("R7 rd untouched", A_FRD, 2);
        @(negedge clk);
        dram_wr_pulse = 1;
        @(negedge clk);
        dram_wr_pulse = 0;
        rd_chk("R7 resumes", A_FWR, 1);
        wr(A_FCLR, 2);
        rd_chk("R7 rd cleared", A_FRD, 0);
        rd_chk("R7 wr kept", A_FWR, 1);
    endtask

    task automatic t_unmapped;
        rd_chk("R9 gap", 18'h20004, 0);
        rd_chk("R9 misaligned", A_CFG + 4, 0);
        rd_chk("R9 end status", A_DONE, 0);
        wr(A_CFG + 33, '1);
        rd_chk("R9 misaligned write", A_CFG + 32, 0);
        wr(A_VAL, 64'h55);
        rd_chk("R9 value write ignored", A_VAL, 6);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_gating();
        t_independent();
        t_multi();
        t_wrap();
        t_fixed();
        t_clear();
        t_unmapped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule